// File: doc/BRIEF.md
# Delimited Packet CRC-32 Checker

This block sits on a receive path that carries one byte per clock, each byte tagged with a flag that marks it as a control character rather than data. It looks for two programmable control characters, one that opens a packet and one that closes it. Between them it folds every data byte into a CRC-32. The last four data bytes before the closing character are the transmitted check field, and they are folded in as well. When the closing character arrives, the block compares the CRC register against the fixed residue that a good packet leaves.

The byte stream and its control flag reach the outputs in the same cycle they arrive. The result is reported on two flags that line up with the closing character as it leaves the block. One flag marks that a packet has just been judged, and the other marks that it failed. An enable input switches the whole check off, and the stream still passes through while it is off.

The CRC is the non-reflected form. Polynomial 0x04C11DB7 is applied MSB first, with the register seeded to all ones. The sender appends the complement of its register, most significant byte first, so a clean packet leaves 0xC704DD7B in the register.

Top module: `pkt_crc_check`

## Requirements
- R1: `out_data` and `out_ctrl` equal `in_data` and `in_ctrl` in the same cycle, with no register in between, whether checking is on or off.
- R2: `crc_checking` is high for exactly one cycle. That is the cycle in which a byte with `in_ctrl`=1 and value `eop_char` arrives while a packet is open. The packet is open from a byte with `in_ctrl`=1 and value `sop_char` until the closing byte. A close followed at once by an open in the next cycle starts a new packet.
- R3: A packet whose data bytes are a payload followed by four check bytes leaves no error. The check bytes are the complement of the CRC register over the payload, most significant byte first, with polynomial 0x04C11DB7, all-ones seed and MSB-first bit order. This includes a packet with an empty payload.
- R4: If any data byte between the delimiters is altered, `crc_error` is high together with `crc_checking`. `crc_error` is never high without `crc_checking`.
- R5: A closing character that arrives while no packet is open produces no flags. This covers a closing character before any opening one and a second closing character after a packet has ended.
- R6: A packet with fewer than four data bytes between its delimiters is reported with `crc_error`=1.
- R7: While `chk_en`=0 no flag is raised, and an open packet is dropped. A closing character that arrives after enable returns, without a new opening character, produces no flags. This holds even when `chk_en` falls in the same cycle as the closing character.
- R8: Delimiters are recognised only with `in_ctrl`=1. A byte equal to `sop_char` or `eop_char` with `in_ctrl`=0 is packet data. Other control characters inside a packet are not folded into the CRC. Changing `sop_char`/`eop_char` moves the delimiters to the new values.
- R9: An opening character inside an open packet discards what has been gathered and restarts the CRC.
- R10: While reset is held, both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Enables packet tracking and flags |
| sop_char | input | 8 | Control character that opens a packet |
| eop_char | input | 8 | Control character that closes a packet |
| in_data | input | 8 | Incoming byte |
| in_ctrl | input | 1 | Incoming byte is a control character |
| out_data | output | 8 | Byte passed through, same cycle |
| out_ctrl | output | 1 | Control flag passed through, same cycle |
| crc_checking | output | 1 | A packet was judged on this cycle |
| crc_error | output | 1 | The packet judged on this cycle failed |

## Verification
Two things can land on one byte and must both be judged: the verdict on the closing character and the pass-through of that same character. A second case is the verdict and the removal of `chk_en` in one cycle. The bench drives a closing character in the very cycle it drops `chk_en`. It expects the byte on `out_data` unchanged but both flags low, and it expects a later closing character to stay silent. It also sends a closing character followed at once by the next opening character. The verdict of the first packet and the start of the second are then checked on adjacent cycles.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD  = 32'hC704DD7B;
    localparam int unsigned FCS_BYTES = 4;
endpackage

// File: rtl/pkt_crc_step.sv
module pkt_crc_step #(
    parameter int unsigned          DW   = 8,
    parameter int unsigned          CW   = 32,
    parameter logic [CW-1:0]        POLY = 32'h04C11DB7
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] byte_in,
    output logic [CW-1:0] crc_out
);
    always_comb begin
        logic [CW-1:0] acc;
        logic          fb;
        acc = crc_in;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[CW-1] ^ byte_in[i];
            acc = {acc[CW-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/pkt_crc_track.sv
module pkt_crc_track #(
    parameter int unsigned   CW        = 32,
    parameter logic [CW-1:0] SEED      = '1,
    parameter int unsigned   MIN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          open_hit,
    input  logic          close_hit,
    input  logic          data_hit,
    input  logic [CW-1:0] crc_next,
    output logic          active,
    output logic [CW-1:0] crc_cur,
    output logic          too_short
);
    localparam int unsigned CNT_W = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

    typedef struct packed {
        logic            active;
        logic [CW-1:0]   crc;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.active = 1'b0;
        end else if (st_q.active && close_hit) begin
            st_d.active = 1'b0;
        end else if (open_hit) begin
            st_d.active = 1'b1;
            st_d.crc    = SEED;
            st_d.cnt    = '0;
        end else if (st_q.active && data_hit) begin
            st_d.crc = crc_next;
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.crc    <= SEED;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign crc_cur   = st_q.crc;
    assign too_short = (st_q.cnt != CNT_MAX);
endmodule

// File: rtl/pkt_crc_check.sv
module pkt_crc_check
    import pkt_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [BYTE_W-1:0] sop_char,
    input  logic [BYTE_W-1:0] eop_char,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_ctrl,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_ctrl,
    output logic              crc_checking,
    output logic              crc_error
);
    logic             open_hit, close_hit, data_hit;
    logic             active, too_short;
    logic [CRC_W-1:0] crc_cur, crc_next;

    assign open_hit  = in_ctrl && (in_data == sop_char);
    assign close_hit = in_ctrl && (in_data == eop_char);
    assign data_hit  = !in_ctrl;

    pkt_crc_step #(.DW(BYTE_W), .CW(CRC_W), .POLY(CRC_POLY)) step_i (
        .crc_in (crc_cur),
        .byte_in(in_data),
        .crc_out(crc_next)
    );

    pkt_crc_track #(.CW(CRC_W), .SEED(CRC_SEED), .MIN_BYTES(FCS_BYTES)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (chk_en),
        .open_hit (open_hit),
        .close_hit(close_hit),
        .data_hit (data_hit),
        .crc_next (crc_next),
        .active   (active),
        .crc_cur  (crc_cur),
        .too_short(too_short)
    );

    always_comb begin
        logic judge;
        judge        = chk_en && active && close_hit;
        crc_checking = judge;
        crc_error    = judge && (too_short || (crc_cur != CRC_GOOD));
    end

    assign out_data = in_data;
    assign out_ctrl = in_ctrl;
endmodule

// File: rtl/pkt_crc_check_sva.sv
module pkt_crc_check_sva
    import pkt_crc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chk_en,
    input logic [BYTE_W-1:0] sop_char,
    input logic [BYTE_W-1:0] eop_char,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_ctrl,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_ctrl,
    input logic              crc_checking,
    input logic              crc_error
);
    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data == in_data) && (out_ctrl == in_ctrl));

    assert_judge_on_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        crc_checking |-> (in_ctrl && in_data == eop_char));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        crc_checking |=> !crc_checking);

    assert_err_with_judge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> crc_checking);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> !(crc_checking || crc_error));

    always_comb begin
        if (!rst_n) assert_reset_quiet_R10: assert (!crc_checking && !crc_error);
    end
endmodule

bind pkt_crc_check pkt_crc_check_sva chk_i (.*);

// File: tb/pkt_crc_check_tb_top.sv
module pkt_crc_check_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_en = 1'b1;
    logic [7:0] sop_char = 8'hFB;
    logic [7:0] eop_char = 8'hFD;
    logic [7:0] in_data = 8'h00;
    logic       in_ctrl = 1'b0;
    logic [7:0] out_data;
    logic       out_ctrl, crc_checking, crc_error;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pkt_crc_check dut_i (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .sop_char(sop_char), .eop_char(eop_char),
        .in_data(in_data), .in_ctrl(in_ctrl),
        .out_data(out_data), .out_ctrl(out_ctrl),
        .crc_checking(crc_checking), .crc_error(crc_error)
    );

    typedef struct {
        logic [7:0] d;
        logic       c;
        logic       xc;
        logic       xe;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] pl_q[$];

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic drive(input logic [7:0] d, input logic c, input logic en,
                         input logic xc, input logic xe, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        in_data = d;
        in_ctrl = c;
        chk_en  = en;
        it.d = d; it.c = c; it.xc = xc; it.xe = xe; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Opening char, pl_q as data, optional check field, closing char.
    task automatic send_pkt(input bit add_fcs, input int flip_idx,
                            input logic xe, input string tag);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] fcs;
        foreach (pl_q[i]) c = ref_crc(c, pl_q[i]);
        fcs = ~c;
        drive(sop_char, 1'b1, 1'b1, 1'b0, 1'b0, tag);
        foreach (pl_q[i]) begin
            logic [7:0] b;
            b = pl_q[i];
            if (i == flip_idx) b = b ^ 8'h10;
            drive(b, 1'b0, 1'b1, 1'b0, 1'b0, tag);
        end
        if (add_fcs) begin
            for (int k = 3; k >= 0; k--)
                drive(fcs[8*k +: 8], 1'b0, 1'b1, 1'b0, 1'b0, tag);
        end
        drive(eop_char, 1'b1, 1'b1, 1'b1, xe, tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (out_data !== it.d || out_ctrl !== it.c ||
                    crc_checking !== it.xc || crc_error !== it.xe) begin
                    n_fail++;
                    $display("FAIL %s: got d=%h c=%b chk=%b err=%b, exp d=%h c=%b chk=%b err=%b",
                             it.tag, out_data, out_ctrl, crc_checking, crc_error,
                             it.d, it.c, it.xc, it.xe);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        // R10: flags low during reset even with a closing char on the input
        in_ctrl = 1'b1;
        in_data = eop_char;
        repeat (3) @(posedge clk);
        #3;
        n_run++;
        if (crc_checking !== 1'b0 || crc_error !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: got chk=%b err=%b, exp 0 0", crc_checking, crc_error);
        end
        in_ctrl = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle data passes through
        drive(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        drive(8'hBC, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        // R5: closing char before any opening char
        drive(eop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R5");

        // R3/R8: good packet, payload holds delimiter values as plain data
        pl_q = '{8'h01, 8'hFD, 8'hFB, 8'h7E, 8'h00, 8'hC3};
        send_pkt(1'b1, -1, 1'b0, "R3");
        // R5: second closing char after the packet ended
        drive(eop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R5");

        // R4: same packet with one payload bit flipped
        send_pkt(1'b1, 2, 1'b1, "R4");

        // R3: empty payload, only the check field
        pl_q = {};
        send_pkt(1'b1, -1, 1'b0, "R3");

        // R6: short packets (two bytes, zero bytes)
        pl_q = '{8'hAA, 8'h55};
        send_pkt(1'b0, -1, 1'b1, "R6");
        pl_q = {};
        send_pkt(1'b0, -1, 1'b1, "R6");

        // R9: opening char inside an open packet restarts the CRC
        drive(sop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        drive(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        drive(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        pl_q = '{8'h10, 8'h20, 8'h30};
        send_pkt(1'b1, -1, 1'b0, "R9");

        // R8: a non-delimiter control char inside a packet is not data
        drive(sop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'h10, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'h1C, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        pl_q = '{8'h10};
        begin
            logic [31:0] c;
            c = ~ref_crc(32'hFFFFFFFF, 8'h10);
            for (int k = 3; k >= 0; k--)
                drive(c[8*k +: 8], 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        end
        drive(eop_char, 1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // R2: close then open on the next cycle, both packets judged
        pl_q = '{8'h9A, 8'hBC};
        send_pkt(1'b1, -1, 1'b0, "R2");
        send_pkt(1'b1, 0, 1'b1, "R2");

        // R7: whole packet while disabled gives no flags
        drive(sop_char, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        drive(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        drive(eop_char, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        // R7: disable mid-packet, close after re-enable stays silent
        drive(sop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        drive(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        drive(eop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        // R7: enable falls on the very closing cycle
        drive(sop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        drive(8'h01, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        drive(eop_char, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        drive(eop_char, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        // R8: move the delimiters; old closing char is no longer one
        @(posedge clk);
        #1;
        sop_char = 8'h3C;
        eop_char = 8'h5C;
        drive(8'hFB, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'hFD, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        pl_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h42};
        send_pkt(1'b1, -1, 1'b0, "R8");
        send_pkt(1'b1, 4, 1'b1, "R8");

        drive(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule